// File: doc/BRIEF.md
# Three-wire serial command slave

This block is the device side of a three-wire serial control port: a clock from the master (SCLK), an active-low frame enable (SEN, here `sen_n`) and one bidirectional data pin (SDIO). The block runs on a fast system clock and passes all three inputs through a synchronizer. It finds SCLK edges by comparing successive synchronized samples. Every frame starts with one control byte. Bit 7 of that byte gives the direction and the other seven bits form an opcode for the core.

A write frame carries eight argument bytes. When the last argument bit arrives, the block raises a one-cycle strobe. The 64-bit argument block and the opcode then stay on their outputs until a later write replaces them. A read frame turns the data line around after the control byte and shifts out sixteen response bytes. The response comes from a copy of the core's response word, taken when the control byte completes. The block drives a tri-state enable for the pad. Raising the enable at any time ends the frame: counters return to zero and the pad is released.

Top module: `tw_cmd_slave`

## Requirements
- R1: The control byte is received most significant bit first on SCLK rising edges. Control bit 7 = 1 selects a read frame and bit 7 = 0 selects a write frame. Control bits 6..0 are the opcode.
- R2: A write frame takes the next 64 bits, most significant bit first, on SCLK rising edges. The first bit received lands in `wr_args[63]`. After the 64th bit, `wr_stb` is high for exactly one system clock and `wr_opcode`/`wr_args` take the new frame's values. Between strobes, `wr_opcode` and `wr_args` do not change.
- R3: `sdio_oe` stays 0 for the whole of a write frame.
- R4: A read frame sends the 128 bits of the response, `rsp_data[127]` first and `rsp_data[0]` last. Each bit appears on `sdio_out` with `sdio_oe` = 1 after an SCLK falling edge and is held until the next falling edge.
- R5: Bus turnaround: in a read frame, `sdio_oe` stays 0 during the control byte and after its eighth rising edge. It goes to 1 only after the first SCLK falling edge that follows that eighth rising edge.
- R6: After the last read bit, `sdio_oe` returns to 0 following the next SCLK falling edge and stays 0 for the rest of the frame.
- R7: `rsp_data` is captured when the control byte completes. Changes to `rsp_data` after that point do not affect the bits sent in the frame.
- R8: Setting `sen_n` high at any point ends the frame. `sdio_oe` drops to 0 and the bit counters reset, so the next frame starts with a new control byte. A write frame cut short never raises `wr_stb` and leaves `wr_opcode`/`wr_args` unchanged.
- R9: While reset is asserted and just after it, `sdio_oe`, `sdio_out` and `wr_stb` are 0 and `wr_opcode` and `wr_args` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| sen_n | input | 1 | Active-low frame enable from the master |
| sdio_in | input | 1 | Data pin as seen from the pad input |
| sdio_out | output | 1 | Data value driven onto the pad during reads |
| sdio_oe | output | 1 | Pad output enable; 1 drives the pin |
| rsp_data | input | 128 | Response bytes from the core, byte 0 in bits 127..120 |
| wr_stb | output | 1 | One-cycle pulse when a write frame completes |
| wr_opcode | output | 7 | Opcode of the last completed write frame |
| wr_args | output | 64 | Argument block of the last completed write, first byte in bits 63..56 |

## Verification
The hardest conditions to reach are a read that is aborted while the slave is driving the pin, and a core response that changes in the middle of a read frame. The master model in the bench drops the enable after a few response bits and checks that the pad is released. It then runs a complete read to show that the counters started again from zero. In another read it inverts `rsp_data` just after the turnaround edge and expects every one of the sixteen bytes to carry the value captured earlier. A write cut off after twenty argument bits is checked the same way. No strobe may arrive, and the outputs must still hold the arguments of the earlier write.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        TW_CTRL  = 2'd0,
        TW_WDATA = 2'd1,
        TW_RDATA = 2'd2,
        TW_DONE  = 2'd3
    } tw_state_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RESET_VAL[g]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/tw_frame.sv
module tw_frame
    import tw_pkg::*;
#(
    parameter int CTRL_BITS = 8,
    parameter int WR_BYTES  = 8,
    parameter int RD_BYTES  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk_s,
    input  logic                      sen_n_s,
    input  logic                      sdio_s,
    input  logic [RD_BYTES*8-1:0]     rsp_data,
    output logic                      sdio_out,
    output logic                      sdio_oe,
    output logic                      wr_stb,
    output logic [CTRL_BITS-2:0]      wr_opcode,
    output logic [WR_BYTES*8-1:0]     wr_args
);

    localparam int WR_BITS  = WR_BYTES * 8;
    localparam int RD_BITS  = RD_BYTES * 8;
    localparam int OP_W     = CTRL_BITS - 1;
    localparam int MAX_A    = (WR_BITS > CTRL_BITS) ? WR_BITS : CTRL_BITS;
    localparam int MAX_BITS = (RD_BITS > MAX_A) ? RD_BITS : MAX_A;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    typedef struct packed {
        tw_state_e            st;
        logic                 sclk_prev;
        logic [CNT_W-1:0]     cnt;
        logic [OP_W-1:0]      ctl;
        logic [OP_W-1:0]      op_pend;
        logic [WR_BITS-2:0]   wsh;
        logic [RD_BITS-1:0]   rsh;
        logic                 oe;
        logic                 dout;
        logic                 stb;
        logic [OP_W-1:0]      op;
        logic [WR_BITS-1:0]   args;
    } frame_t;

    frame_t q, d;
    logic   rise;
    logic   fall;

    always_comb begin
        rise = sclk_s & ~q.sclk_prev;
        fall = ~sclk_s & q.sclk_prev;

        d           = q;
        d.sclk_prev = sclk_s;
        d.stb       = 1'b0;

        if (sen_n_s) begin
            d.st   = TW_CTRL;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.dout = 1'b0;
        end else begin
            unique case (q.st)
                TW_CTRL: begin
                    if (rise) begin
                        d.ctl = {q.ctl[OP_W-2:0], sdio_s};
                        if (q.cnt == CNT_W'(CTRL_BITS - 1)) begin
                            d.cnt     = '0;
                            d.op_pend = {q.ctl[OP_W-2:0], sdio_s};
                            if (q.ctl[OP_W-1]) begin
                                d.st  = TW_RDATA;
                                d.rsh = rsp_data;
                            end else begin
                                d.st  = TW_WDATA;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                TW_WDATA: begin
                    if (rise) begin
                        d.wsh = {q.wsh[WR_BITS-3:0], sdio_s};
                        if (q.cnt == CNT_W'(WR_BITS - 1)) begin
                            d.cnt  = '0;
                            d.stb  = 1'b1;
                            d.op   = q.op_pend;
                            d.args = {q.wsh, sdio_s};
                            d.st   = TW_DONE;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                TW_RDATA: begin
                    if (fall) begin
                        if (q.cnt == CNT_W'(RD_BITS)) begin
                            d.oe   = 1'b0;
                            d.dout = 1'b0;
                            d.cnt  = '0;
                            d.st   = TW_DONE;
                        end else begin
                            d.oe   = 1'b1;
                            d.dout = q.rsh[RD_BITS-1];
                            d.rsh  = {q.rsh[RD_BITS-2:0], 1'b0};
                            d.cnt  = q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    d.oe   = 1'b0;
                    d.dout = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TW_CTRL, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sdio_out  = q.dout;
    assign sdio_oe   = q.oe;
    assign wr_stb    = q.stb;
    assign wr_opcode = q.op;
    assign wr_args   = q.args;

endmodule

// File: rtl/tw_cmd_slave.sv
module tw_cmd_slave #(
    parameter int CTRL_BITS   = 8,
    parameter int WR_BYTES    = 8,
    parameter int RD_BYTES    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  sen_n,
    input  logic                  sdio_in,
    output logic                  sdio_out,
    output logic                  sdio_oe,
    input  logic [RD_BYTES*8-1:0] rsp_data,
    output logic                  wr_stb,
    output logic [CTRL_BITS-2:0]  wr_opcode,
    output logic [WR_BYTES*8-1:0] wr_args
);

    logic [2:0] raw_in;
    logic [2:0] synced;

    assign raw_in = {sdio_in, sen_n, sclk};

    tw_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b010)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    tw_frame #(
        .CTRL_BITS (CTRL_BITS),
        .WR_BYTES  (WR_BYTES),
        .RD_BYTES  (RD_BYTES)
    ) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (synced[0]),
        .sen_n_s   (synced[1]),
        .sdio_s    (synced[2]),
        .rsp_data  (rsp_data),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .wr_stb    (wr_stb),
        .wr_opcode (wr_opcode),
        .wr_args   (wr_args)
    );

endmodule

// File: rtl/tw_cmd_slave_chk.sv
module tw_cmd_slave_chk #(
    parameter int CTRL_BITS = 8,
    parameter int WR_BYTES  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sen_n,
    input logic                  sdio_out,
    input logic                  sdio_oe,
    input logic                  wr_stb,
    input logic [CTRL_BITS-2:0]  wr_opcode,
    input logic [WR_BYTES*8-1:0] wr_args
);

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R2

    AST_ARGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> ($stable(wr_args) && $stable(wr_opcode))); // R2

    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !sdio_oe); // R3

    AST_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sen_n, 1) && $past(sen_n, 2) && $past(sen_n, 3) && $past(sen_n, 4))
        |-> !sdio_oe); // R8

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sdio_oe |=> (!$rose(sdio_out) || sdio_oe)); // R6

endmodule

bind tw_cmd_slave tw_cmd_slave_chk #(
    .CTRL_BITS (CTRL_BITS),
    .WR_BYTES  (WR_BYTES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sen_n     (sen_n),
    .sdio_out  (sdio_out),
    .sdio_oe   (sdio_oe),
    .wr_stb    (wr_stb),
    .wr_opcode (wr_opcode),
    .wr_args   (wr_args)
);

// File: tb/test_tw_cmd_slave.sv
`timescale 1ns/1ps
module test_tw_cmd_slave;

    localparam int HALF = 80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sen_n = 1'b1;
    logic         sdio_in = 1'b0;
    logic         sdio_out;
    logic         sdio_oe;
    logic [127:0] rsp_data = '0;
    logic         wr_stb;
    logic [6:0]   wr_opcode;
    logic [63:0]  wr_args;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    logic oe_seen = 1'b0;
    logic finished = 1'b0;
    logic [70:0] exp_q[$];

    always #2.5 clk = ~clk;

    tw_cmd_slave i_tw_cmd_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sen_n     (sen_n),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .rsp_data  (rsp_data),
        .wr_stb    (wr_stb),
        .wr_opcode (wr_opcode),
        .wr_args   (wr_args)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: scoreboard for completed write frames
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            strobes++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 actual unexpected strobe %h expected none", wr_args);
            end else begin
                logic [70:0] e;
                e = exp_q.pop_front();
                if ({wr_opcode, wr_args} !== e) begin
                    errors++;
                    $display("FAIL R2 actual %h expected %h", {wr_opcode, wr_args}, e);
                end
            end
        end
    end

    task automatic send_bit(input logic b);
        sdio_in = b;
        #HALF sclk = 1'b1;
        oe_seen = oe_seen | sdio_oe;
        #HALF sclk = 1'b0;
        oe_seen = oe_seen | sdio_oe;
    endtask

    task automatic do_write(input logic [6:0] op, input logic [63:0] args, input int nbits);
        if (nbits == 64) exp_q.push_back({op, args});
        oe_seen = 1'b0;
        sen_n = 1'b0;
        #HALF;
        for (int i = 7; i >= 0; i--) send_bit(i == 7 ? 1'b0 : op[i]);
        for (int i = 63; i >= 64 - nbits; i--) send_bit(args[i]);
        #HALF;
        check("R3 oe during write", {127'd0, oe_seen}, 128'd0);
        sen_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic do_read(input logic [6:0] op, input logic [127:0] exp, input logic flip);
        logic [7:0] got;
        logic       oe_ok;
        oe_ok = 1'b1;
        sen_n = 1'b0;
        #HALF;
        for (int i = 7; i >= 1; i--) send_bit(i == 7 ? 1'b1 : op[i]);
        sdio_in = op[0];
        #HALF sclk = 1'b1;
        #(HALF / 2);
        check("R5 oe after control byte", {127'd0, sdio_oe}, 128'd0);
        #(HALF / 2) sclk = 1'b0;
        #(HALF / 2);
        if (flip) rsp_data = ~rsp_data;
        #(HALF / 2);
        for (int k = 0; k < 16; k++) begin
            for (int b = 7; b >= 0; b--) begin
                #(HALF - 1);
                got[b] = sdio_out;
                oe_ok = oe_ok & sdio_oe;
                #1 sclk = 1'b1;
                #HALF sclk = 1'b0;
            end
            check(flip ? "R7 latched byte" : "R4 read byte",
                  {120'd0, got}, {120'd0, exp[127 - 8 * k -: 8]});
        end
        check("R4 oe while driving", {127'd0, oe_ok}, 128'd1);
        #(HALF / 2);
        check("R6 release after last bit", {127'd0, sdio_oe}, 128'd0);
        #HALF sclk = 1'b1;
        #HALF sclk = 1'b0;
        #(HALF / 2);
        check("R6 stays released", {127'd0, sdio_oe}, 128'd0);
        sen_n = 1'b1;
        #(4 * HALF);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0]  last_args;
        logic [6:0]   last_op;
        int           s0;
        repeat (5) @(posedge clk);
        #1;
        check("R9 reset oe", {127'd0, sdio_oe}, 128'd0);
        check("R9 reset outputs", {55'd0, wr_stb, sdio_out, wr_opcode, wr_args}, 128'd0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check("R9 after reset", {55'd0, wr_stb, sdio_oe, wr_opcode, wr_args}, 128'd0);

        // R1 R2: write frames with distinct patterns
        do_write(7'h35, 64'h0123_4567_89AB_CDEF, 64);
        do_write(7'h7F, 64'hFFFF_0000_A5A5_5A5A, 64);
        do_write(7'h00, 64'h8000_0000_0000_0001, 64);
        check("R2 all writes strobed", 128'(exp_q.size()), 128'd0);
        check("R2 strobe count", 128'(strobes), 128'd3);

        // R8: aborted write
        last_args = wr_args;
        last_op = wr_opcode;
        s0 = strobes;
        do_write(7'h11, 64'hDEAD_BEEF_CAFE_F00D, 20);
        check("R8 no strobe on abort", 128'(strobes), 128'(s0));
        check("R8 outputs kept", {57'd0, wr_opcode, wr_args}, {57'd0, last_op, last_args});
        do_write(7'h22, 64'h1111_2222_3333_4444, 64);
        check("R8 write after abort", 128'(exp_q.size()), 128'd0);

        // R4 R5 R6: read frames
        rsp_data = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        do_read(7'h12, rsp_data, 1'b0);
        rsp_data = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
        do_read(7'h40, rsp_data, 1'b0);

        // R7: response captured at end of control byte
        rsp_data = 128'h5A5A5A5A_C3C3C3C3_0F0F0F0F_12345678;
        do_read(7'h05, 128'h5A5A5A5A_C3C3C3C3_0F0F0F0F_12345678, 1'b1);

        // R8: aborted read then full read
        sen_n = 1'b0;
        #HALF;
        for (int i = 7; i >= 0; i--) send_bit(i == 7 ? 1'b1 : 1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b0);
        check("R8 driving before abort", {127'd0, sdio_oe}, 128'd1);
        sen_n = 1'b1;
        #(HALF / 2);
        check("R8 released on abort", {127'd0, sdio_oe}, 128'd0);
        #(4 * HALF);
        rsp_data = 128'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90;
        do_read(7'h33, rsp_data, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule